// File: doc/BRIEF.md
# Variable-Page-Size Translation Lookup Table

This block keeps a table of 64-bit translation entries and, on request, searches it for the entry that maps a given 32-bit virtual address in a given address space. Each entry carries its own page size, from 4 KB to 1 GB. The size is encoded as the position of the lowest set bit of the whole entry. Software fills and inspects the table one entry at a time by index. Reads are combinational. A write applies at the next clock edge.

A lookup starts with a one-cycle start strobe that carries a 9-bit address-space ID and a virtual address. The engine then checks one entry per clock, beginning at index 0. It reports the first matching index, the physical page base and the size code of that match. When nothing matches it reports a fixed not-found index. If a second entry also matches, the scan stops at once and the block raises a multi-match flag as a separate cause. The flag does not replace the first match. A one-cycle done pulse marks the point where the results become valid. The results then hold until the next lookup starts. Permission checks and overlap checks are done elsewhere.

Top module: `vpt_tlb`

## Requirements
- R1: After reset every entry reads as zero, busy and done are low, hit and multi are low, and the reported index is 32'h8000_0000.
- R2: While no lookup is running, a write stores the 64-bit data at the given index by the next edge, and the read port returns the entry at the read index combinationally.
- R3: Entry layout: bits 23:0 hold the physical descriptor, bits 31:24 hold permission and cache fields that the lookup ignores, bits 51:32 hold the VPN, bits 58:52 hold the ASID, bit 61 is the extra physical bit, bit 62 is global and bit 63 is valid. The size code c is the number of trailing zeros of the entry, and an all-zero entry counts as 0. The page size is 4096 << 2c. An entry with c of 10 or more never matches. On a hit, the size output carries c.
- R4: An entry matches an address when base <= VA < base + size. The base is VPN << 12 with its low 12+2c bits cleared.
- R5: An entry whose valid bit is clear never matches.
- R6: The entry ASID is compared with the low 8 bits of the input ASID. The compare is skipped when the entry's global bit is set or when input ASID bit 8 is set.
- R7: The physical base output is {bit61, bits 23:1} << 12 (36 bits), with its low 12+2c bits cleared.
- R8: The first matching index is reported with hit high. With no match, hit is low, the index is 32'h8000_0000, and the base and size read zero.
- R9: When a second match is found, the scan stops on that entry and multi goes high. The index, base and size still describe the first match. Done then arrives k+2 cycles after the start edge, where k is the second match's index.
- R10: Without a second match the scan visits all entries, and done rises DEPTH+1 cycles after the start edge as a single-cycle pulse. Busy covers the scan, and a start strobe seen while busy is ignored.
- R11: A write issued while busy does not change the table during the scan. It is applied on the edge that ends the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IW | Entry write index |
| wr_data | input | 64 | Entry write data |
| rd_idx | input | IW | Entry read index |
| rd_data | output | 64 | Entry at rd_idx |
| lk_start | input | 1 | Lookup start strobe |
| lk_asid | input | 9 | Lookup address-space ID; bit 8 disables the ID compare |
| lk_va | input | 32 | Lookup virtual address |
| lk_busy | output | 1 | Scan in progress |
| lk_done | output | 1 | One-cycle end-of-scan pulse |
| lk_hit | output | 1 | A match was found |
| lk_multi | output | 1 | A second match was found |
| lk_index | output | 32 | First match index or 32'h8000_0000 |
| lk_size | output | 4 | Size code of the first match |
| lk_pbase | output | 36 | Physical page base of the first match |

## Verification
The hardest state to reach from the ports is a write landing while a scan is in flight. The write must target an entry the scan has not yet visited, and it must be shown to take effect only once the scan has ended. The bench issues such a write two cycles into a scan that is heading for entry 3. It reads entry 3 through the read port while busy and again after done, then repeats the lookup to show the new value now applies. Early multi-match stops and ignored start strobes are reached the same way: the bench counts cycles from the start edge and acts at a known point of the scan.

// File: rtl/vpt_tlb.sv
module vpt_tlb #(
  parameter int DEPTH = 16,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [63:0]   wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [63:0]   rd_data,
  input  logic          lk_start,
  input  logic [8:0]    lk_asid,
  input  logic [31:0]   lk_va,
  output logic          lk_busy,
  output logic          lk_done,
  output logic          lk_hit,
  output logic          lk_multi,
  output logic [31:0]   lk_index,
  output logic [3:0]    lk_size,
  output logic [35:0]   lk_pbase
);

  logic [63:0]   tbl [DEPTH];
  logic [IW-1:0] ptr, hit_idx, pend_idx;
  logic [8:0]    q_asid;
  logic [31:0]   q_va;
  logic          busy, done, found, multi, pend_v;
  logic [3:0]    hit_code;
  logic [35:0]   hit_pa;
  logic [63:0]   pend_data;

  logic [63:0] cur;
  logic [5:0]  tz;
  logic [3:0]  code;
  logic [31:0] vmask;
  logic        size_ok, asid_ok, va_ok, cur_hit, last, finish;
  logic [35:0] cur_pa;

  assign cur = tbl[ptr];

  always_comb begin
    tz = 6'd0;
    for (int i = 63; i >= 0; i--)
      if (cur[i]) tz = 6'(i);
  end

  assign size_ok = (tz < 6'd10);
  assign code    = size_ok ? tz[3:0] : 4'd0;
  assign vmask   = (32'h1 << (6'd12 + {1'b0, code, 1'b0})) - 32'h1;
  assign va_ok   = ((q_va & ~vmask) == ({cur[51:32], 12'h000} & ~vmask));
  assign asid_ok = cur[62] | q_asid[8] | (q_asid[7:0] == {1'b0, cur[58:52]});
  assign cur_hit = cur[63] & size_ok & asid_ok & va_ok;
  assign cur_pa  = {cur[61], cur[23:1], 12'h000} & ~{4'h0, vmask};
  assign last    = (ptr == IW'(DEPTH - 1));
  assign finish  = busy & ((cur_hit & found) | last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      ptr      <= '0;
      q_asid   <= '0;
      q_va     <= '0;
      found    <= 1'b0;
      multi    <= 1'b0;
      hit_idx  <= '0;
      hit_code <= '0;
      hit_pa   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (lk_start) begin
          busy     <= 1'b1;
          ptr      <= '0;
          q_asid   <= lk_asid;
          q_va     <= lk_va;
          found    <= 1'b0;
          multi    <= 1'b0;
          hit_idx  <= '0;
          hit_code <= '0;
          hit_pa   <= '0;
        end
      end else begin
        if (cur_hit) begin
          if (found) multi <= 1'b1;
          else begin
            found    <= 1'b1;
            hit_idx  <= ptr;
            hit_code <= code;
            hit_pa   <= cur_pa;
          end
        end
        if (finish) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          ptr <= ptr + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
      pend_v    <= 1'b0;
      pend_idx  <= '0;
      pend_data <= '0;
    end else begin
      if (!busy) begin
        if (wr_en) tbl[wr_idx] <= wr_data;
      end else if (finish) begin
        pend_v <= 1'b0;
        if (pend_v) tbl[pend_idx] <= pend_data;
        if (wr_en) tbl[wr_idx] <= wr_data;
      end else if (wr_en) begin
        pend_v    <= 1'b1;
        pend_idx  <= wr_idx;
        pend_data <= wr_data;
      end
    end
  end

  assign rd_data  = tbl[rd_idx];
  assign lk_busy  = busy;
  assign lk_done  = done;
  assign lk_hit   = found;
  assign lk_multi = multi;
  assign lk_index = found ? 32'(hit_idx) : 32'h8000_0000;
  assign lk_size  = hit_code;
  assign lk_pbase = hit_pa;

endmodule

// File: rtl/vpt_tlb_chk.sv
module vpt_tlb_chk #(
  parameter int DEPTH = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        lk_start,
  input logic        lk_busy,
  input logic        lk_done,
  input logic        lk_hit,
  input logic        lk_multi,
  input logic [31:0] lk_index
);

  a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    lk_done |-> $past(lk_busy));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    lk_done |=> !lk_done);

  a_r10_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lk_busy) |-> lk_done);

  a_r10_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_busy && lk_start) |=> (lk_busy || lk_done));

  a_r9_multi_has_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_done && lk_multi) |-> lk_hit);

  a_r8_miss_index: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_done && !lk_hit) |-> (lk_index == 32'h8000_0000));

  a_r8_hit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_done && lk_hit) |-> (lk_index < 32'(DEPTH)));

endmodule

bind vpt_tlb vpt_tlb_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lk_start (lk_start),
  .lk_busy  (lk_busy),
  .lk_done  (lk_done),
  .lk_hit   (lk_hit),
  .lk_multi (lk_multi),
  .lk_index (lk_index)
);

// File: tb/vpt_tlb_bench.sv
module vpt_tlb_bench;
  localparam int DEPTH = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [63:0]   wr_data = '0;
  logic [IW-1:0] rd_idx = '0;
  logic [63:0]   rd_data;
  logic          lk_start = 1'b0;
  logic [8:0]    lk_asid = '0;
  logic [31:0]   lk_va = '0;
  logic          lk_busy, lk_done, lk_hit, lk_multi;
  logic [31:0]   lk_index;
  logic [3:0]    lk_size;
  logic [35:0]   lk_pbase;

  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  vpt_tlb #(.DEPTH(DEPTH)) u_vpt_tlb (.*);

  typedef struct packed {
    logic [8:0]  asid;
    logic [31:0] va;
    logic        hit;
    logic [31:0] idx;
    logic        multi;
    logic [3:0]  code;
    logic [35:0] pa;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{9'h005, 32'h0001_0ABC, 1'b1, 32'd3 - 32'd3, 1'b0, 4'd0, 36'h0_0ABC_D000}, // R4 4K hit
    '{9'h006, 32'h0001_0ABC, 1'b0, 32'h8000_0000, 1'b0, 4'd0, 36'h0},          // R6 ASID mismatch
    '{9'h100, 32'h0001_0FFF, 1'b1, 32'd0, 1'b0, 4'd0, 36'h0_0ABC_D000},         // R6 no-ASID, R4 top byte
    '{9'h100, 32'h0001_1000, 1'b0, 32'h8000_0000, 1'b0, 4'd0, 36'h0},          // R4 one past end
    '{9'h033, 32'h005A_5A5A, 1'b1, 32'd1, 1'b0, 4'd5, 36'h8_0040_0000},         // R6 global, R7 bit 61
    '{9'h005, 32'h0002_0123, 1'b0, 32'h8000_0000, 1'b0, 4'd0, 36'h0},          // R5 invalid skipped
    '{9'h007, 32'h0002_0123, 1'b1, 32'd3, 1'b0, 4'd1, 36'h0_0002_0000},         // R3 16K
    '{9'h007, 32'h0002_2010, 1'b1, 32'd3, 1'b1, 4'd1, 36'h0_0002_0000},         // R9 multi
    '{9'h009, 32'h0003_0000, 1'b0, 32'h8000_0000, 1'b0, 4'd0, 36'h0},          // R3 code 10 never hits
    '{9'h003, 32'h7FFF_FFFF, 1'b1, 32'd6, 1'b0, 4'd9, 36'h0},                  // R3 1G, R4 rounding
    '{9'h003, 32'h8000_0000, 1'b0, 32'h8000_0000, 1'b0, 4'd0, 36'h0},          // R4 above 1G page
    '{9'h003, 32'h3FFF_FFFF, 1'b0, 32'h8000_0000, 1'b0, 4'd0, 36'h0},          // R4 below 1G page
    '{9'h100, 32'h0002_2FFF, 1'b1, 32'd3, 1'b1, 4'd1, 36'h0_0002_0000}          // R9 multi, no ASID
  };

  function automatic logic [63:0] mk(logic v, logic g, logic [6:0] asid,
                                     logic [19:0] vpn, logic b61, logic [23:0] ppd);
    return {v, g, b61, 2'b00, asid, vpn, 4'b1010, 4'b0011, ppd};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int idx, output logic [63:0] d);
    rd_idx = IW'(idx);
    #1 d = rd_data;
  endtask

  task automatic lookup(logic [8:0] a, logic [31:0] v, output int n);
    @(negedge clk);
    lk_start = 1'b1; lk_asid = a; lk_va = v;
    @(negedge clk);
    lk_start = 1'b0;
    n = 1;
    while (!lk_done && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(8 * 200000);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [63:0] d;
    int n;
    logic [63:0] ent [DEPTH];
    ent[0] = mk(1, 0, 7'h05, 20'h00010, 0, 24'h01579B);
    ent[1] = mk(1, 1, 7'h00, 20'h00400, 1, 24'h000820);
    ent[2] = mk(0, 0, 7'h05, 20'h00020, 0, 24'h000001);
    ent[3] = mk(1, 0, 7'h07, 20'h00020, 0, 24'h000042);
    ent[4] = mk(1, 0, 7'h07, 20'h00022, 0, 24'h000101);
    ent[5] = mk(1, 0, 7'h09, 20'h00030, 0, 24'h000400);
    ent[6] = mk(1, 0, 7'h03, 20'h40001, 0, 24'h000200);
    ent[7] = 64'h0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", 64'(lk_busy), 64'h0);
    check("R1 done", 64'(lk_done), 64'h0);
    check("R1 hit", 64'(lk_hit), 64'h0);
    check("R1 index", 64'(lk_index), 64'h8000_0000);
    for (int i = 0; i < DEPTH; i++) begin
      rd(i, d);
      check("R1 entry zero", d, 64'h0);
    end

    // R2 write and read back
    for (int i = 0; i < DEPTH; i++) wr(i, ent[i]);
    for (int i = 0; i < DEPTH; i++) begin
      rd(i, d);
      check("R2 readback", d, ent[i]);
    end

    // R3..R9 vector table
    for (int k = 0; k < 13; k++) begin
      lookup(VECS[k].asid, VECS[k].va, n);
      check("R8 hit", 64'(lk_hit), 64'(VECS[k].hit));
      check("R8 index", 64'(lk_index), 64'(VECS[k].idx));
      check("R9 multi", 64'(lk_multi), 64'(VECS[k].multi));
      check("R3 size", 64'(lk_size), 64'(VECS[k].code));
      check("R7 pbase", 64'(lk_pbase), 64'(VECS[k].pa));
      check("R10 R9 done cycle", 64'(n), VECS[k].multi ? 64'd6 : 64'(DEPTH + 1));
    end

    // R10 done is a single pulse and results hold afterwards
    lookup(9'h007, 32'h0002_0123, n);
    @(negedge clk);
    check("R10 done pulse", 64'(lk_done), 64'h0);
    check("R10 busy idle", 64'(lk_busy), 64'h0);
    check("R10 result held", 64'(lk_index), 64'd3);

    // R10 start while busy ignored
    @(negedge clk);
    lk_start = 1'b1; lk_asid = 9'h007; lk_va = 32'h0002_0123;
    @(negedge clk);
    lk_asid = 9'h005; lk_va = 32'h0001_0ABC;
    @(negedge clk);
    lk_start = 1'b0;
    n = 2;
    while (!lk_done && n < 100) begin @(negedge clk); n++; end
    check("R10 second start ignored idx", 64'(lk_index), 64'd3);
    check("R10 second start ignored cyc", 64'(n), 64'(DEPTH + 1));
    @(negedge clk);
    check("R10 no restart", 64'(lk_busy), 64'h0);

    // R11 write during scan deferred
    @(negedge clk);
    lk_start = 1'b1; lk_asid = 9'h007; lk_va = 32'h0002_0123;
    @(negedge clk);
    lk_start = 1'b0;
    wr_en = 1'b1; wr_idx = 3'd3; wr_data = 64'h0;
    @(negedge clk);
    wr_en = 1'b0;
    rd(3, d);
    check("R11 held during scan", d, ent[3]);
    n = 2;
    while (!lk_done && n < 100) begin @(negedge clk); n++; end
    check("R11 scan saw old entry", 64'(lk_index), 64'd3);
    rd(3, d);
    check("R11 applied after scan", d, 64'h0);
    lookup(9'h007, 32'h0002_0123, n);
    check("R11 new entry in effect", 64'(lk_index), 64'h8000_0000);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule